// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a 32-bit virtual address into a physical address in two steps. The three most significant address bits pick one of eight segment registers. Each segment register holds a valid flag, the base address of a page table and a page-count limit. The 17-bit page field is checked against that limit. If the check passes, one page-table entry is fetched through a read port with a fixed latency of one cycle. The entry's valid, read and write flags are then checked against the kind of access. The result is either a physical address, made of the entry's frame number followed by the untouched 12-bit offset, or a single access-error flag.

Requests arrive on a valid/ready handshake, and only one translation is in flight at a time. A response is a one-cycle `rsp_done` pulse. The segment registers can be written and read back through a separate configuration port, so that an operating system can save and restore them on a context switch.

Top module: `seg_page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` and `mem_rd_en` are 0, and every segment register reads back as invalid.
- R2: A cycle with `cfg_we` high stores base, limit and valid flag into the register numbered `cfg_idx`. The `cfg_r*` outputs show the register selected by `cfg_idx` combinationally.
- R3: The segment register is selected by virtual-address bits [31:29], and the page number is bits [28:12].
- R4: A request through a segment whose valid flag is 0 responds with error one cycle after acceptance, and no table read is made.
- R5: A page number greater than or equal to the segment limit (an 18-bit value, so 2^17 allows every page) responds with error one cycle after acceptance, and no table read is made.
- R6: A request that passes the checks makes exactly one table read, at address base + 4 × page. It responds three cycles after acceptance, using data returned in the cycle after `mem_rd_en`.
- R7: An entry whose valid flag (entry bit 0) is 0 gives an error.
- R8: A write to an entry with write flag (bit 2) at 0 gives an error. A read of an entry with read flag (bit 1) at 0 gives an error.
- R9: A translation that passes every check gives `rsp_err` = 0 and `rsp_paddr` = {entry bits [22:3], vaddr[11:0]}.
- R10: `rsp_err` and a non-zero `rsp_paddr` appear only while `rsp_done` is high. `rsp_paddr` is 0 on an error.
- R11: `req_ready` is low from the acceptance of a table-walking request until its response. A request presented in that time is neither accepted nor answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Access error for this response |
| rsp_paddr | output | 32 | Physical address, 0 on error |
| mem_rd_en | output | 1 | Page-table read strobe |
| mem_rd_addr | output | 32 | Page-table entry byte address |
| mem_rd_data | input | 23 | Entry: frame number [22:3], write [2], read [1], valid [0] |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_idx | input | 3 | Segment register number for write and read-back |
| cfg_wbase | input | 32 | Page-table base to store |
| cfg_wlimit | input | 18 | Page-count limit to store |
| cfg_wvalid | input | 1 | Segment valid flag to store |
| cfg_rbase | output | 32 | Read-back base |
| cfg_rlimit | output | 18 | Read-back limit |
| cfg_rvalid | output | 1 | Read-back valid flag |

## Verification
Responses that fail at the segment stage (R4, R5) must have `rsp_done` one cycle after the accepting edge. Responses that walk the table must have it three cycles after, with the read strobe in the first of those cycles. The bench drives inputs on falling edges and counts falling edges from acceptance to the strobe. It then compares that count with the latency its own model predicts. At the same sample it compares the error flag, the address and the number of table reads seen. Read-back of the configuration registers is sampled one falling edge after the write edge.

// File: rtl/seg_page_xlate.sv
module seg_page_xlate #(
  parameter int VA_W  = 32,
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PPN_W = 20,
  parameter int PTA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [VA_W-1:0]              req_vaddr,
  input  logic                         req_write,
  output logic                         rsp_done,
  output logic                         rsp_err,
  output logic [PPN_W+OFF_W-1:0]       rsp_paddr,
  output logic                         mem_rd_en,
  output logic [PTA_W-1:0]             mem_rd_addr,
  input  logic [PPN_W+2:0]             mem_rd_data,
  input  logic                         cfg_we,
  input  logic [SEG_W-1:0]             cfg_idx,
  input  logic [PTA_W-1:0]             cfg_wbase,
  input  logic [VA_W-SEG_W-OFF_W:0]    cfg_wlimit,
  input  logic                         cfg_wvalid,
  output logic [PTA_W-1:0]             cfg_rbase,
  output logic [VA_W-SEG_W-OFF_W:0]    cfg_rlimit,
  output logic                         cfg_rvalid
);
  localparam int PG_W = VA_W - SEG_W - OFF_W;
  localparam int NSEG = 1 << SEG_W;
  localparam int PA_W = PPN_W + OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_CHECK} st_t;

  logic [PTA_W-1:0] seg_base [NSEG];
  logic [PG_W:0]    seg_lim  [NSEG];
  logic [NSEG-1:0]  seg_vld;

  st_t              st;
  logic [OFF_W-1:0] off_q;
  logic             wr_q;

  logic [SEG_W-1:0] seg;
  logic [PG_W-1:0]  page;
  logic             seg_bad;
  logic             pte_bad;
  logic             accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        seg_base[i] <= '0;
        seg_lim[i]  <= '0;
      end
      seg_vld <= '0;
    end else if (cfg_we) begin
      seg_base[cfg_idx] <= cfg_wbase;
      seg_lim[cfg_idx]  <= cfg_wlimit;
      seg_vld[cfg_idx]  <= cfg_wvalid;
    end
  end

  assign cfg_rbase  = seg_base[cfg_idx];
  assign cfg_rlimit = seg_lim[cfg_idx];
  assign cfg_rvalid = seg_vld[cfg_idx];

  assign seg     = req_vaddr[VA_W-1 -: SEG_W];
  assign page    = req_vaddr[OFF_W +: PG_W];
  assign seg_bad = !seg_vld[seg] || ({1'b0, page} >= seg_lim[seg]);

  assign pte_bad = !mem_rd_data[0] || (wr_q ? !mem_rd_data[2] : !mem_rd_data[1]);

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_rd_en = (st == S_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      off_q       <= '0;
      wr_q        <= 1'b0;
      mem_rd_addr <= '0;
      rsp_done    <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_paddr   <= '0;
    end else begin
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_paddr <= '0;
      case (st)
        S_IDLE: if (accept) begin
          if (seg_bad) begin
            rsp_done <= 1'b1;
            rsp_err  <= 1'b1;
          end else begin
            st          <= S_ISSUE;
            off_q       <= req_vaddr[OFF_W-1:0];
            wr_q        <= req_write;
            mem_rd_addr <= seg_base[seg] + {{(PTA_W-PG_W-2){1'b0}}, page, 2'b00};
          end
        end
        S_ISSUE: st <= S_CHECK;
        S_CHECK: begin
          st       <= S_IDLE;
          rsp_done <= 1'b1;
          rsp_err  <= pte_bad;
          if (!pte_bad) rsp_paddr <= {mem_rd_data[PPN_W+2:3], off_q};
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic unused_pa;
  assign unused_pa = ^PA_W;
endmodule

// File: rtl/seg_page_xlate_chk.sv
module seg_page_xlate_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_rd_en,
  input logic            rsp_done,
  input logic            rsp_err,
  input logic [PA_W-1:0] rsp_paddr
);
  assert_accept_progress_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_done || mem_rd_en));

  assert_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en ##1 rsp_done);

  assert_err_in_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  assert_err_zero_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_paddr == '0));

  assert_busy_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);
endmodule

bind seg_page_xlate seg_page_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_rd_en (mem_rd_en),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .rsp_paddr (rsp_paddr)
);

// File: tb/seg_page_xlate_bench.sv
module seg_page_xlate_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_vaddr = 0;
  logic        req_write = 0;
  logic        rsp_done, rsp_err;
  logic [31:0] rsp_paddr;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [22:0] mem_rd_data = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_idx = 0;
  logic [31:0] cfg_wbase = 0;
  logic [17:0] cfg_wlimit = 0;
  logic        cfg_wvalid = 0;
  logic [31:0] cfg_rbase;
  logic [17:0] cfg_rlimit;
  logic        cfg_rvalid;

  always #2.5 clk = ~clk;

  seg_page_xlate u_seg_page_xlate (.*);

  int n_chk = 0, n_fail = 0, rd_cnt = 0;
  logic [31:0] last_addr = 0;
  logic [31:0] sh_base [8];
  logic [17:0] sh_lim  [8];
  bit          sh_vld  [8];

  function automatic logic [22:0] pte_fn(input logic [31:0] a);
    return {a[31:12] ^ {a[11:2], a[21:12]}, a[4:2] ^ a[9:7]};
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) begin
    rd_cnt      <= rd_cnt + 1;
    last_addr   <= mem_rd_addr;
    mem_rd_data <= pte_fn(mem_rd_addr);
  end

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr_seg(input int i, input logic [31:0] b, input logic [17:0] l, input bit v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = i[2:0]; cfg_wbase = b; cfg_wlimit = l; cfg_wvalid = v;
    @(negedge clk);
    cfg_we = 0;
    sh_base[i] = b; sh_lim[i] = l; sh_vld[i] = v;
    chk(cfg_rbase == b && cfg_rlimit == l && cfg_rvalid == v, "R2 readback",
        {cfg_rvalid, cfg_rlimit, cfg_rbase}, {v, l, b});
  endtask

  task automatic do_req(input logic [31:0] va, input bit wr, input bit hold);
    int seg = va[31:29];
    logic [16:0] pg = va[28:12];
    logic [31:0] ea = sh_base[seg] + {13'd0, pg, 2'b00};
    logic [22:0] pte = pte_fn(ea);
    bit walk, e_err;
    logic [31:0] e_pa;
    string tag;
    int n, rd0;
    walk = 0; e_err = 1; e_pa = 0;
    if (!sh_vld[seg]) tag = "R4 invalid segment";
    else if ({1'b0, pg} >= sh_lim[seg]) tag = "R5 page over limit";
    else begin
      walk = 1;
      if (!pte[0]) tag = "R7 invalid entry";
      else if (wr && !pte[2]) tag = "R8 write to read-only";
      else if (!wr && !pte[1]) tag = "R8 read not allowed";
      else begin tag = "R9 translation R3"; e_err = 0; e_pa = {pte[22:3], va[11:0]}; end
    end
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr;
    rd0 = rd_cnt;
    @(negedge clk);
    n = 1;
    if (hold) req_vaddr = va ^ 32'h0000_1000;
    else req_valid = 0;
    if (walk) chk(!req_ready, "R11 busy", req_ready, 0);
    while (!rsp_done && n < 20) begin
      @(negedge clk); n++;
      if (n == 2) req_valid = 0;
    end
    req_valid = 0;
    chk(n < 20, {tag, " watchdog"}, n, 0);
    chk(n == (walk ? 3 : 1), {tag, " latency R6"}, n, walk ? 3 : 1);
    chk(rsp_err == e_err && rsp_paddr == e_pa, tag, {rsp_err, rsp_paddr}, {e_err, e_pa});
    chk(rd_cnt - rd0 == (walk ? 1 : 0), {tag, " read count R6"}, rd_cnt - rd0, walk ? 1 : 0);
    if (walk) chk(last_addr == ea, "R6 entry address", last_addr, ea);
    if (hold) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!rsp_done && rd_cnt - rd0 == 1, "R11 stalled request ignored", rsp_done, 0);
      end
    end
  endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin sh_base[i] = 0; sh_lim[i] = 0; sh_vld[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_done && !mem_rd_en, "R1 reset outputs", {req_ready, rsp_done, mem_rd_en}, 3'b100);
    for (int i = 0; i < 8; i++) begin
      cfg_idx = i[2:0]; #0.1;
      chk(!cfg_rvalid, "R1 segment invalid", cfg_rvalid, 0);
    end

    wr_seg(1, 32'h0010_0000, 18'd0, 1);
    wr_seg(2, 32'h0010_0000, 18'd16, 1);
    wr_seg(7, 32'h0800_0000, 18'h20000, 1);
    do_req(32'h0000_0123, 0, 0);
    do_req(32'h2000_5abc, 0, 0);
    do_req(32'h4001_0000, 0, 0);
    do_req(32'h4000_f004, 0, 0);
    do_req(32'h4000_0000, 0, 0);
    do_req(32'h4000_3010, 1, 0);
    do_req(32'h4000_3010, 0, 0);
    do_req(32'h4000_5020, 0, 0);
    do_req(32'h4000_5020, 1, 0);
    do_req(32'h4000_7fff, 1, 0);
    do_req(32'hffff_fabc, 0, 0);
    do_req(32'h4000_7abc, 0, 1);

    for (int i = 0; i < 8; i++)
      wr_seg(i, $urandom & 32'hffff_fffc, 18'($urandom % 300), ($urandom % 8) != 0);
    for (int t = 0; t < 400; t++) begin
      logic [2:0] s = 3'($urandom);
      logic [16:0] p = 17'($urandom % (sh_lim[s] + sh_lim[s] / 4 + 1));
      if (t % 50 == 49)
        wr_seg($urandom % 8, $urandom & 32'hffff_fffc, 18'($urandom % 300), 1);
      do_req({s, p, 12'($urandom)}, 1'($urandom), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule